// File: doc/BRIEF.md
# Coprocessor Bus Interface Register Slave

This block is the host-facing register front end of a floating-point coprocessor. A host drives an asynchronous select strobe, a read/write flag, a 5-bit location address and a 32-bit write bus. The block brings the select into its own clock domain and decodes the location. It returns read data and one or two acknowledge lines that tell the host how wide the addressed port is. Every 16-bit location moves its data on the upper half of the bus. Locations that cannot be read in the requested direction, or that do not exist, return all ones.

Accepted writes go to the execution core as a one-cycle write strobe, with a target code and the write data. A small dialog sequencer tracks one instruction. A command write arms it. The first read of the response location after that write releases execution. While executing, the core can post an operand-transfer request. Reading that request back turns the response to null, and the sequencer then waits for an operand access.

Top module: `cpif_slave`

## Requirements
- R1: After reset both acknowledges are low, the read bus is zero, no write strobe or start pulse is issued, and the response location reads as the null code.
- R2: Each select assertion is acknowledged once the select has passed through the synchronizer. This holds for reserved and unimplemented locations too. The acknowledge and the read data stay stable while the select is held, and both acknowledges drop after the select is released.
- R3: The 32-bit locations assert both acknowledges: operand (A4..A2 = 100), register select (A4..A1 = 1010), instruction address (A4..A2 = 110) and operand address (A4..A2 = 111). Every other location asserts only ack_upper.
- R4: For 16-bit locations, read data sits on bits 31:16 with bits 15:0 zero, and write data is taken from bits 31:16. This holds whatever the value of A1. A register-select read places its value on both halves.
- R5: Reads of write-only locations, of the operand-address and operation-word locations, and of the reserved locations return 32'hFFFF_FFFF. The write-only locations are control (A4..A1 = 0001), command (0101), condition (0111) and instruction address. The operation-word location is 0100 and the reserved locations are 0110 and 1011.
- R6: Writes to the read-only locations produce no write strobe and change nothing readable. The read-only locations are response (0000), save (0010) and register select. Writes to operation word, operand address and the reserved locations behave the same way.
- R7: Each accepted write gives exactly one wr_strobe cycle. The target codes are control 0, restore 1, command 2, condition 3, operand 4 and instruction address 5. wr_data holds the full 32 bits for 32-bit locations and {16'h0, bits 31:16} for 16-bit locations.
- R8: The restore location (0011) reads back the last value written to it.
- R9: The response location can be read in every dialog state. Its null code is 16'h0802 and its transfer-request code is 16'h8C03.
- R10: A command write latches cmd_word and arms the sequencer. exec_start pulses once, on the first response read after that write. Later response reads give no further pulse.
- R11: While executing, a core_xfer_req cycle makes the response read as the transfer code. Reading it back makes the response null, and a new core_xfer_req then has no effect until an operand access.
- R12: An operand read or write in the waiting state returns the sequencer to executing, so core_xfer_req takes effect again. A core_done cycle while executing returns it to idle, where core_xfer_req is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Asynchronous host select, active high |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 5 | Location address A4..A0 |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Registered read data |
| ack_upper | output | 1 | Acknowledge, upper-half port |
| ack_lower | output | 1 | Acknowledge, lower half (long port when set with ack_upper) |
| core_save | input | 16 | Value presented at the save location |
| core_rsel | input | 16 | Value presented at the register-select location |
| core_opnd | input | 32 | Value returned by operand reads |
| core_xfer_req | input | 1 | Core requests an operand transfer |
| core_done | input | 1 | Core finished the current instruction |
| wr_strobe | output | 1 | One-cycle pulse per accepted write |
| wr_target | output | 3 | Target code of the write |
| wr_data | output | 32 | Data of the write |
| exec_start | output | 1 | One-cycle pulse releasing execution |
| cmd_word | output | 16 | Last command written |

## Verification
A wrong dialog state shows at the ports on the next response read. That read returns the wrong code, or exec_start pulses early, twice, or not at all. A decode fault shows on the very access it affects: the acknowledge pair has the wrong width, the data lands on the wrong bus half, a forbidden read does not return all ones, or a stray wr_strobe appears. A stuck acknowledge is caught within the release window of the same access.

// File: rtl/cpif_pkg.sv
package cpif_pkg;
  typedef enum logic [3:0] {
    K_RSP, K_CTL, K_SAVE, K_RESTORE, K_OPW, K_CMD, K_RSV, K_COND,
    K_OPND, K_RSEL, K_IADDR, K_OPA
  } loc_e;

  typedef enum logic [2:0] {
    WT_CTL = 3'd0, WT_RESTORE = 3'd1, WT_CMD = 3'd2,
    WT_COND = 3'd3, WT_OPND = 3'd4, WT_IADDR = 3'd5
  } wtgt_e;

  typedef enum logic [2:0] {
    D_IDLE, D_ARMED, D_EXEC, D_SVC, D_WAITOP
  } dlg_e;

  typedef struct packed {
    loc_e loc;
    logic is_long;
  } loc_info_t;
endpackage

// File: rtl/cpif_sync.sv
module cpif_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] shreg;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      last  <= 1'b0;
    end else begin
      shreg <= {shreg[STAGES-2:0], async_in};
      last  <= shreg[STAGES-1];
    end
  end

  assign level = shreg[STAGES-1];
  assign rise  = shreg[STAGES-1] & ~last;
endmodule

// File: rtl/cpif_decode.sv
module cpif_decode
  import cpif_pkg::*;
(
  input  logic [3:0] addr_hi,
  output loc_info_t  info
);
  always_comb begin
    info.is_long = 1'b0;
    info.loc     = K_RSV;
    case (addr_hi)
      4'b0000: info.loc = K_RSP;
      4'b0001: info.loc = K_CTL;
      4'b0010: info.loc = K_SAVE;
      4'b0011: info.loc = K_RESTORE;
      4'b0100: info.loc = K_OPW;
      4'b0101: info.loc = K_CMD;
      4'b0110: info.loc = K_RSV;
      4'b0111: info.loc = K_COND;
      4'b1000, 4'b1001: begin info.loc = K_OPND;  info.is_long = 1'b1; end
      4'b1010:          begin info.loc = K_RSEL;  info.is_long = 1'b1; end
      4'b1011:          info.loc = K_RSV;
      4'b1100, 4'b1101: begin info.loc = K_IADDR; info.is_long = 1'b1; end
      default:          begin info.loc = K_OPA;   info.is_long = 1'b1; end
    endcase
  end
endmodule

// File: rtl/cpif_dialog.sv
module cpif_dialog
  import cpif_pkg::*;
#(
  parameter int             HALF_W    = 16,
  parameter logic [HALF_W-1:0] NULL_PRIM = 16'h0802,
  parameter logic [HALF_W-1:0] XFER_PRIM = 16'h8C03
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic              rsp_rd,
  input  logic              opnd_acc,
  input  logic              xfer_req,
  input  logic              done,
  output logic [HALF_W-1:0] rsp_word,
  output logic              exec_start
);
  dlg_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= D_IDLE;
      exec_start <= 1'b0;
    end else begin
      exec_start <= (state == D_ARMED) && rsp_rd;
      if (cmd_wr) state <= D_ARMED;
      else begin
        case (state)
          D_ARMED:  if (rsp_rd) state <= D_EXEC;
          D_EXEC:   if (done) state <= D_IDLE;
                    else if (xfer_req) state <= D_SVC;
          D_SVC:    if (rsp_rd) state <= D_WAITOP;
          D_WAITOP: if (opnd_acc) state <= D_EXEC;
          default:  state <= state;
        endcase
      end
    end
  end

  assign rsp_word = (state == D_SVC) ? XFER_PRIM : NULL_PRIM;

  // R10: a start pulse only follows a response read taken while armed
  assert_start_after_arm_R10: assert property (@(posedge clk) disable iff (rst)
    exec_start |-> ($past(state) == D_ARMED && $past(rsp_rd)));

  // R11: reading the transfer request moves the dialog to operand wait
  assert_svc_read_waits_R11: assert property (@(posedge clk) disable iff (rst)
    (state == D_SVC && rsp_rd && !cmd_wr) |=> (state == D_WAITOP));
endmodule

// File: rtl/cpif_slave.sv
module cpif_slave
  import cpif_pkg::*;
#(
  parameter int                DATA_W      = 32,
  parameter int                ADDR_W      = 5,
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W/2-1:0] NULL_PRIM = 16'h0802,
  parameter logic [DATA_W/2-1:0] XFER_PRIM = 16'h8C03
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_sel,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                ack_upper,
  output logic                ack_lower,
  input  logic [DATA_W/2-1:0] core_save,
  input  logic [DATA_W/2-1:0] core_rsel,
  input  logic [DATA_W-1:0]   core_opnd,
  input  logic                core_xfer_req,
  input  logic                core_done,
  output logic                wr_strobe,
  output logic [2:0]          wr_target,
  output logic [DATA_W-1:0]   wr_data,
  output logic                exec_start,
  output logic [DATA_W/2-1:0] cmd_word
);
  localparam int HALF_W = DATA_W / 2;

  logic              sel_s, acc;
  loc_info_t         info;
  logic [HALF_W-1:0] rsp_word, restore_q;
  logic [DATA_W-1:0] rd_value, wr_value;
  logic              wr_ok;
  wtgt_e             wr_tgt;
  logic              unused_a0;

  assign unused_a0 = bus_addr[0];

  cpif_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(bus_sel), .level(sel_s), .rise(acc)
  );

  cpif_decode u_dec (.addr_hi(bus_addr[ADDR_W-1:1]), .info(info));

  cpif_dialog #(.HALF_W(HALF_W), .NULL_PRIM(NULL_PRIM), .XFER_PRIM(XFER_PRIM)) u_dlg (
    .clk(clk), .rst(rst),
    .cmd_wr(acc && !bus_rd && info.loc == K_CMD),
    .rsp_rd(acc && bus_rd && info.loc == K_RSP),
    .opnd_acc(acc && info.loc == K_OPND),
    .xfer_req(core_xfer_req), .done(core_done),
    .rsp_word(rsp_word), .exec_start(exec_start)
  );

  always_comb begin
    case (info.loc)
      K_RSP:     rd_value = {rsp_word, {HALF_W{1'b0}}};
      K_SAVE:    rd_value = {core_save, {HALF_W{1'b0}}};
      K_RESTORE: rd_value = {restore_q, {HALF_W{1'b0}}};
      K_RSEL:    rd_value = {core_rsel, core_rsel};
      K_OPND:    rd_value = core_opnd;
      default:   rd_value = '1;
    endcase
  end

  always_comb begin
    wr_ok  = 1'b1;
    wr_tgt = WT_CTL;
    case (info.loc)
      K_CTL:     wr_tgt = WT_CTL;
      K_RESTORE: wr_tgt = WT_RESTORE;
      K_CMD:     wr_tgt = WT_CMD;
      K_COND:    wr_tgt = WT_COND;
      K_OPND:    wr_tgt = WT_OPND;
      K_IADDR:   wr_tgt = WT_IADDR;
      default:   wr_ok  = 1'b0;
    endcase
    wr_value = info.is_long ? bus_wdata : {{HALF_W{1'b0}}, bus_wdata[DATA_W-1:HALF_W]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_upper <= 1'b0;
      ack_lower <= 1'b0;
      bus_rdata <= '0;
      wr_strobe <= 1'b0;
      wr_target <= WT_CTL;
      wr_data   <= '0;
      cmd_word  <= '0;
      restore_q <= '0;
    end else begin
      wr_strobe <= 1'b0;
      if (acc) begin
        ack_upper <= 1'b1;
        ack_lower <= info.is_long;
        if (bus_rd) bus_rdata <= rd_value;
        else if (wr_ok) begin
          wr_strobe <= 1'b1;
          wr_target <= wr_tgt;
          wr_data   <= wr_value;
          if (info.loc == K_RESTORE) restore_q <= bus_wdata[DATA_W-1:HALF_W];
          if (info.loc == K_CMD)     cmd_word  <= bus_wdata[DATA_W-1:HALF_W];
        end
      end else if (!sel_s) begin
        ack_upper <= 1'b0;
        ack_lower <= 1'b0;
      end
    end
  end

  // R3: the lower acknowledge never appears without the upper one
  assert_lower_needs_upper_R3: assert property (@(posedge clk) disable iff (rst)
    ack_lower |-> ack_upper);

  // R2: a released select clears the acknowledge on the next edge
  assert_release_drops_ack_R2: assert property (@(posedge clk) disable iff (rst)
    !sel_s |=> !ack_upper);

  // R2: read data holds while the acknowledge is held
  assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (ack_upper && $past(ack_upper)) |-> $stable(bus_rdata));

  // R7: a write strobe only comes with a fresh acknowledge
  assert_strobe_with_ack_R7: assert property (@(posedge clk) disable iff (rst)
    wr_strobe |-> $rose(ack_upper));
endmodule

// File: tb/cpif_slave_tb.sv
module cpif_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] NULL_C = 16'h0802;
  localparam logic [15:0] XFER_C = 16'h8C03;
  localparam logic [15:0] SAVE_C = 16'h1357;
  localparam logic [15:0] RSEL_C = 16'h2468;
  localparam logic [31:0] OPND_C = 32'hC0DE_F00D;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ack_upper, ack_lower;
  logic        core_xfer_req = 1'b0, core_done = 1'b0;
  logic        wr_strobe, exec_start;
  logic [2:0]  wr_target;
  logic [31:0] wr_data;
  logic [15:0] cmd_word;

  int checks = 0, fails = 0, cyc = 0;
  int strobe_cnt = 0, exec_cnt = 0;
  logic [2:0]  last_tgt;
  logic [31:0] last_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpif_slave u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ack_upper(ack_upper),
    .ack_lower(ack_lower), .core_save(SAVE_C), .core_rsel(RSEL_C), .core_opnd(OPND_C),
    .core_xfer_req(core_xfer_req), .core_done(core_done), .wr_strobe(wr_strobe),
    .wr_target(wr_target), .wr_data(wr_data), .exec_start(exec_start), .cmd_word(cmd_word)
  );

  always @(negedge clk) begin
    if (wr_strobe) begin
      strobe_cnt++;
      last_tgt  = wr_target;
      last_data = wr_data;
    end
    if (exec_start) exec_cnt++;
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic rd, input logic [4:0] a, input logic [31:0] wd,
                        output logic [31:0] rdv, output logic au, output logic al);
    int n;
    @(negedge clk);
    bus_rd = rd; bus_addr = a; bus_wdata = wd; bus_sel = 1'b1;
    n = 0;
    while (!ack_upper && n < 40) begin @(negedge clk); n++; end
    rdv = bus_rdata; au = ack_upper; al = ack_lower;
    @(negedge clk);
    chk(bus_rdata == rdv && ack_upper == au, "R2 hold", bus_rdata, rdv);
    bus_sel = 1'b0;
    n = 0;
    while (ack_upper && n < 40) begin @(negedge clk); n++; end
    chk(!ack_upper && !ack_lower, "R2 release", {30'd0, ack_upper, ack_lower}, 32'd0);
    @(negedge clk);
  endtask

  task automatic pulse_core(input bit xf);
    @(negedge clk);
    if (xf) core_xfer_req = 1'b1; else core_done = 1'b1;
    @(negedge clk);
    core_xfer_req = 1'b0; core_done = 1'b0;
  endtask

  function automatic bit exp_long(input logic [4:0] a);
    return a[4:2] == 3'b100 || a[4:1] == 4'b1010 || a[4:3] == 2'b11;
  endfunction

  function automatic logic [31:0] exp_read(input logic [4:0] a, input logic [15:0] rst_v,
                                           input logic [15:0] rsp);
    if (a[4:1] == 4'b0000) return {rsp, 16'h0};
    if (a[4:1] == 4'b0010) return {SAVE_C, 16'h0};
    if (a[4:1] == 4'b0011) return {rst_v, 16'h0};
    if (a[4:1] == 4'b1010) return {RSEL_C, RSEL_C};
    if (a[4:2] == 3'b100)  return OPND_C;
    return 32'hFFFF_FFFF;
  endfunction

  function automatic int exp_tgt(input logic [4:0] a);
    case (a[4:1])
      4'b0001: return 0;
      4'b0011: return 1;
      4'b0101: return 2;
      4'b0111: return 3;
      4'b1000, 4'b1001: return 4;
      4'b1100, 4'b1101: return 5;
      default: return -1;
    endcase
  endfunction

  initial begin
    logic [31:0] rv, wd, ed;
    logic        au, al, rd;
    logic [4:0]  a;
    logic [15:0] restore_m;
    int          s0, e0, exp_exec, tg;
    bit          armed;

    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!ack_upper && !ack_lower, "R1 acks", {30'd0, ack_upper, ack_lower}, 32'd0);
    chk(bus_rdata == 32'd0, "R1 rdata", bus_rdata, 32'd0);
    chk(strobe_cnt == 0 && exec_cnt == 0, "R1 pulses", strobe_cnt, 0);
    access(1'b1, 5'h00, 32'd0, rv, au, al);
    chk(rv == {NULL_C, 16'h0} && au && !al, "R1 R9 null response", rv, {NULL_C, 16'h0});

    // R4 R8: restore write takes upper half, reads back on upper half
    access(1'b0, 5'h06, 32'hABCD_1234, rv, au, al);
    chk(last_tgt == 3'd1 && last_data == 32'h0000_ABCD, "R4 R7 restore write", last_data, 32'h0000_ABCD);
    access(1'b1, 5'h07, 32'd0, rv, au, al);
    chk(rv == 32'hABCD_0000, "R8 restore readback", rv, 32'hABCD_0000);
    restore_m = 16'hABCD;

    // R3 R5: unimplemented and reserved reads
    access(1'b1, 5'h1C, 32'd0, rv, au, al);
    chk(rv == 32'hFFFF_FFFF && au && al, "R3 R5 operand address", rv, 32'hFFFF_FFFF);
    access(1'b1, 5'h0C, 32'd0, rv, au, al);
    chk(rv == 32'hFFFF_FFFF && au && !al, "R3 R5 reserved", rv, 32'hFFFF_FFFF);
    access(1'b1, 5'h14, 32'd0, rv, au, al);
    chk(rv == {RSEL_C, RSEL_C} && al, "R3 R4 register select", rv, {RSEL_C, RSEL_C});

    // R6: write to response is ignored
    s0 = strobe_cnt;
    access(1'b0, 5'h00, 32'hFFFF_FFFF, rv, au, al);
    chk(strobe_cnt == s0 && au, "R6 read-only write", strobe_cnt, s0);
    access(1'b1, 5'h00, 32'd0, rv, au, al);
    chk(rv == {NULL_C, 16'h0}, "R6 response unchanged", rv, {NULL_C, 16'h0});

    // R10: command arms, first response read starts
    access(1'b0, 5'h0A, 32'h5A5A_0000, rv, au, al);
    chk(cmd_word == 16'h5A5A && exec_cnt == 0, "R10 armed no start", exec_cnt, 0);
    access(1'b1, 5'h00, 32'd0, rv, au, al);
    chk(exec_cnt == 1, "R10 start on first read", exec_cnt, 1);
    access(1'b1, 5'h00, 32'd0, rv, au, al);
    chk(exec_cnt == 1, "R10 single start", exec_cnt, 1);

    // R11: transfer request dialog
    pulse_core(1'b1);
    access(1'b1, 5'h00, 32'd0, rv, au, al);
    chk(rv == {XFER_C, 16'h0}, "R11 transfer code", rv, {XFER_C, 16'h0});
    access(1'b1, 5'h00, 32'd0, rv, au, al);
    chk(rv == {NULL_C, 16'h0}, "R11 null after read", rv, {NULL_C, 16'h0});
    pulse_core(1'b1);
    access(1'b1, 5'h01, 32'd0, rv, au, al);
    chk(rv == {NULL_C, 16'h0}, "R11 request ignored while waiting", rv, {NULL_C, 16'h0});

    // R12: operand access resumes execution
    access(1'b0, 5'h10, 32'h1122_3344, rv, au, al);
    chk(last_tgt == 3'd4 && last_data == 32'h1122_3344 && al, "R12 R7 operand write", last_data, 32'h1122_3344);
    pulse_core(1'b1);
    access(1'b1, 5'h00, 32'd0, rv, au, al);
    chk(rv == {XFER_C, 16'h0}, "R12 executing again", rv, {XFER_C, 16'h0});
    access(1'b1, 5'h00, 32'd0, rv, au, al);
    access(1'b1, 5'h12, 32'd0, rv, au, al);
    chk(rv == OPND_C, "R12 operand read", rv, OPND_C);
    pulse_core(1'b0);
    pulse_core(1'b1);
    access(1'b1, 5'h00, 32'd0, rv, au, al);
    chk(rv == {NULL_C, 16'h0}, "R12 idle ignores request", rv, {NULL_C, 16'h0});

    // Random mix against the bench model (core inputs held low)
    armed = 1'b0;
    exp_exec = exec_cnt;
    for (int i = 0; i < 400; i++) begin
      a  = 5'($urandom() % 32);
      rd = 1'($urandom() % 2);
      wd = $urandom();
      s0 = strobe_cnt;
      e0 = exec_cnt;
      access(rd, a, wd, rv, au, al);
      chk(au == 1'b1, "R2 ack random", {31'd0, au}, 32'd1);
      chk(al == exp_long(a), "R3 width random", {31'd0, al}, {31'd0, exp_long(a)});
      if (rd) begin
        ed = exp_read(a, restore_m, NULL_C);
        chk(rv == ed, "R4 R5 R8 read random", rv, ed);
        chk(strobe_cnt == s0, "R6 no strobe on read", strobe_cnt, s0);
        if (a[4:1] == 4'b0000 && armed) begin armed = 1'b0; exp_exec++; end
      end else begin
        tg = exp_tgt(a);
        if (tg < 0) chk(strobe_cnt == s0, "R6 ignored write random", strobe_cnt, s0);
        else begin
          ed = exp_long(a) ? wd : {16'h0, wd[31:16]};
          chk(strobe_cnt == s0 + 1 && int'(last_tgt) == tg && last_data == ed,
              "R7 write random", last_data, ed);
          if (tg == 1) restore_m = wd[31:16];
          if (tg == 2) armed = 1'b1;
        end
      end
      chk(exec_cnt == exp_exec, "R10 start count random", exec_cnt, exp_exec);
    end

    summary();
    $finish;
  end
endmodule